// File: doc/BRIEF.md
# Rotating Tagged Register Stack

This block keeps eight 64-bit floating-point registers. Each register has a one-bit occupancy tag. Operands are named relative to a three-bit top-of-stack pointer that wraps: the operand ST(i) lives in physical register (top + i) mod 8. The block does no arithmetic. It stores values, tracks which registers are occupied, and reports when a request breaks the occupancy rules. When that happens it hands back a quiet NaN, or stores one, in place of the real operand.

The block takes one request per cycle on `op_code`/`op_idx`/`op_wdata`. There are eight requests:

- no operation
- push
- pop
- checked read
- checked write
- read-modify-write
- copy from ST(0)
- examine

Every result is registered, so the response appears on the cycle after the request. That response is:

- `rd_data` and `rd_tag`, which are updated only by the reading requests;
- a fault code in `fault` and a `resp_vld` strobe, which are each high for one cycle;
- the pointer itself, on `top_ptr`.

The block has no control state machine. Its only sequencing state is the top pointer. The pointer takes one of three transitions per request: a step down on push, a step up on pop, or hold on every other request.

Top module: `fprs_stack`

## Requirements
- R1: After reset all eight tags are empty and the top pointer is 0. `rd_data` is 0, `rd_tag` is 0, `fault` is 2'b00 and `resp_vld` is 0.
- R2: The top pointer is three bits and wraps modulo 8. ST(i), for i = `op_idx`, addresses physical register (top + i) mod 8 for both data and tag.
- R3: Push (code 3'd1) sets top to (top - 1) mod 8. It then writes `op_wdata` into the register the new top selects, as a checked write (R6).
- R4: Pop (code 3'd2) returns ST(0) as a checked read (R5), marks that register empty and sets top to (top + 1) mod 8.
- R5: Read (code 3'd3) returns ST(i) and its tag on `rd_data`/`rd_tag`. If the register is empty, `fault` is 2'b01 (underflow) and `rd_data` is 64'h7FF8_0000_0000_0000.
- R6: Write (code 3'd4) and push are checked writes. If the target is already full, `fault` is 2'b10 (overflow) and the NaN pattern is stored instead of `op_wdata`. The target's tag becomes full in every case.
- R7: Modify (code 3'd6) returns ST(i) as a checked read and stores into ST(i). It stores `op_wdata` if ST(i) was full. If ST(i) was empty it stores the NaN pattern and signals underflow. The tag becomes full.
- R8: Examine (code 3'd7) returns the stored data and tag of ST(i) whatever the tag, and never signals a fault.
- R9: Copy (code 3'd5) copies ST(0) into ST(i) and sets ST(i)'s tag full, with no overflow fault even if ST(i) is full. If ST(0) is empty it signals underflow and stores the NaN pattern.
- R10: `fault` and `resp_vld` are single-cycle pulses on the cycle after a request. `resp_vld` is high for every code except no operation (3'd0). No operation changes neither the pointer nor `rd_data`/`rd_tag`, and the fault code 2'b11 never appears.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_code | input | 3 | Request code (see R3 to R10) |
| op_idx | input | 3 | Relative register index i of ST(i) |
| op_wdata | input | 64 | Value for push, write and modify |
| rd_data | output | 64 | Value returned by the last reading request |
| rd_tag | output | 1 | Tag of the register read by the last reading request |
| fault | output | 2 | 00 none, 01 underflow, 10 overflow; one-cycle pulse |
| resp_vld | output | 1 | One-cycle strobe: a request was accepted |
| top_ptr | output | 3 | Current top-of-stack pointer |

## Verification
A wrong tag bit does not show on any port at once. It shows on the next request that touches that register. An empty slot wrongly marked full makes a read return stale data with no underflow. A full slot wrongly marked empty makes a push or write succeed where an overflow was due. The bench therefore follows every stack rotation with examine sweeps over all eight relative indices, so a tag or data error appears within one sweep. A wrong pointer step is visible on `top_ptr` in the very next cycle. Because every relative access depends on the pointer, it also shifts all later read values.

// File: rtl/fprs_pkg.sv
package fprs_pkg;

    typedef enum logic [2:0] {
        OP_NOP    = 3'd0,
        OP_PUSH   = 3'd1,
        OP_POP    = 3'd2,
        OP_READ   = 3'd3,
        OP_WRITE  = 3'd4,
        OP_COPY   = 3'd5,
        OP_MODIFY = 3'd6,
        OP_EXAM   = 3'd7
    } op_e;

    typedef enum logic [1:0] {
        FLT_NONE  = 2'b00,
        FLT_UNDER = 2'b01,
        FLT_OVER  = 2'b10
    } flt_e;

    localparam logic [63:0] QNAN64 = 64'h7FF8_0000_0000_0000;

endpackage

// File: rtl/fprs_topptr.sv
module fprs_topptr #(
    parameter int NREG  = 8,
    localparam int PTR_W = $clog2(NREG)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             step_dn,
    input  logic             step_up,
    output logic [PTR_W-1:0] top
);
    localparam logic [PTR_W-1:0] ONE = 1;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            top <= '0;
        end else if (step_dn) begin
            top <= top - ONE;
        end else if (step_up) begin
            top <= top + ONE;
        end
    end

    AST_ONE_STEP_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        !(step_dn && step_up)); // R2

endmodule

// File: rtl/fprs_regfile.sv
module fprs_regfile #(
    parameter int NREG   = 8,
    parameter int DATA_W = 64,
    localparam int PTR_W = $clog2(NREG)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [PTR_W-1:0]  waddr,
    input  logic [DATA_W-1:0] wval,
    input  logic              clr,
    input  logic [PTR_W-1:0]  caddr,
    input  logic [PTR_W-1:0]  addr_a,
    output logic [DATA_W-1:0] data_a,
    output logic              tag_a,
    input  logic [PTR_W-1:0]  addr_b,
    output logic              tag_b
);
    logic [DATA_W-1:0] data_arr [NREG];
    logic [NREG-1:0]   tag_vec;

    for (genvar k = 0; k < NREG; k++) begin : g_ent
        logic [DATA_W-1:0] d_q;
        logic              t_q;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                d_q <= '0;
                t_q <= 1'b0;
            end else if (we && (waddr == PTR_W'(k))) begin
                d_q <= wval;
                t_q <= 1'b1;
            end else if (clr && (caddr == PTR_W'(k))) begin
                t_q <= 1'b0;
            end
        end
        assign data_arr[k] = d_q;
        assign tag_vec[k]  = t_q;
    end

    assign data_a = data_arr[addr_a];
    assign tag_a  = tag_vec[addr_a];
    assign tag_b  = tag_vec[addr_b];

    AST_WE_CLR_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(we && clr)); // R10

    AST_WRITE_FILLS_TAG: assert property (@(posedge clk) disable iff (!rst_n)
        we |=> tag_vec[$past(waddr)]); // R6

    AST_CLEAR_EMPTIES_TAG: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> !tag_vec[$past(caddr)]); // R4

endmodule

// File: rtl/fprs_ctrl.sv
module fprs_ctrl
    import fprs_pkg::*;
#(
    parameter int                 NREG    = 8,
    parameter int                 DATA_W  = 64,
    parameter logic [DATA_W-1:0]  NAN_PAT = QNAN64[DATA_W-1:0],
    localparam int                PTR_W   = $clog2(NREG)
) (
    input  op_e               op,
    input  logic [PTR_W-1:0]  idx,
    input  logic [PTR_W-1:0]  top,
    input  logic [DATA_W-1:0] wdata,
    input  logic [DATA_W-1:0] data_a,
    input  logic              tag_a,
    input  logic              tag_b,
    output logic [PTR_W-1:0]  addr_a,
    output logic [PTR_W-1:0]  addr_b,
    output logic              we,
    output logic [DATA_W-1:0] wval,
    output logic              clr,
    output logic              step_dn,
    output logic              step_up,
    output logic              rd_upd,
    output logic [DATA_W-1:0] rd_val,
    output logic              rd_tag_val,
    output flt_e              fault_nxt
);
    localparam logic [PTR_W-1:0] ONE = 1;

    logic [PTR_W-1:0] rel;
    logic [PTR_W-1:0] below;
    logic [DATA_W-1:0] checked_a;

    assign rel       = top + idx;
    assign below     = top - ONE;
    assign checked_a = tag_a ? data_a : NAN_PAT;

    always_comb begin
        addr_a     = rel;
        addr_b     = rel;
        we         = 1'b0;
        wval       = wdata;
        clr        = 1'b0;
        step_dn    = 1'b0;
        step_up    = 1'b0;
        rd_upd     = 1'b0;
        rd_val     = checked_a;
        rd_tag_val = tag_a;
        fault_nxt  = FLT_NONE;
        unique case (op)
            OP_NOP: begin
            end
            OP_PUSH: begin
                addr_b    = below;
                we        = 1'b1;
                step_dn   = 1'b1;
                wval      = tag_b ? NAN_PAT : wdata;
                fault_nxt = tag_b ? FLT_OVER : FLT_NONE;
            end
            OP_POP: begin
                addr_a    = top;
                rd_upd    = 1'b1;
                clr       = 1'b1;
                step_up   = 1'b1;
                fault_nxt = tag_a ? FLT_NONE : FLT_UNDER;
            end
            OP_READ: begin
                rd_upd    = 1'b1;
                fault_nxt = tag_a ? FLT_NONE : FLT_UNDER;
            end
            OP_WRITE: begin
                we        = 1'b1;
                wval      = tag_b ? NAN_PAT : wdata;
                fault_nxt = tag_b ? FLT_OVER : FLT_NONE;
            end
            OP_COPY: begin
                addr_a    = top;
                we        = 1'b1;
                wval      = checked_a;
                fault_nxt = tag_a ? FLT_NONE : FLT_UNDER;
            end
            OP_MODIFY: begin
                rd_upd    = 1'b1;
                we        = 1'b1;
                wval      = tag_a ? wdata : NAN_PAT;
                fault_nxt = tag_a ? FLT_NONE : FLT_UNDER;
            end
            OP_EXAM: begin
                rd_upd    = 1'b1;
                rd_val    = data_a;
            end
            default: begin
            end
        endcase
    end

    always_comb begin
        AST_EXAM_QUIET_COMB: assert (op != OP_EXAM || fault_nxt == FLT_NONE); // R8
    end

endmodule

// File: rtl/fprs_stack.sv
module fprs_stack
    import fprs_pkg::*;
#(
    parameter int                NREG    = 8,
    parameter int                DATA_W  = 64,
    parameter logic [DATA_W-1:0] NAN_PAT = QNAN64[DATA_W-1:0],
    localparam int               PTR_W   = $clog2(NREG)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [2:0]        op_code,
    input  logic [PTR_W-1:0]  op_idx,
    input  logic [DATA_W-1:0] op_wdata,
    output logic [DATA_W-1:0] rd_data,
    output logic              rd_tag,
    output logic [1:0]        fault,
    output logic              resp_vld,
    output logic [PTR_W-1:0]  top_ptr
);
    localparam logic [PTR_W-1:0] ONE = 1;

    op_e               op;
    logic [PTR_W-1:0]  top;
    logic [PTR_W-1:0]  addr_a, addr_b;
    logic [DATA_W-1:0] data_a, wval, rd_val;
    logic              tag_a, tag_b;
    logic              we, clr, step_dn, step_up, rd_upd, rd_tag_val;
    flt_e              fault_nxt;
    op_e               last_op;

    assign op = op_e'(op_code);

    fprs_ctrl #(.NREG(NREG), .DATA_W(DATA_W), .NAN_PAT(NAN_PAT)) u_ctrl (
        .op(op), .idx(op_idx), .top(top), .wdata(op_wdata),
        .data_a(data_a), .tag_a(tag_a), .tag_b(tag_b),
        .addr_a(addr_a), .addr_b(addr_b), .we(we), .wval(wval), .clr(clr),
        .step_dn(step_dn), .step_up(step_up), .rd_upd(rd_upd),
        .rd_val(rd_val), .rd_tag_val(rd_tag_val), .fault_nxt(fault_nxt)
    );

    fprs_regfile #(.NREG(NREG), .DATA_W(DATA_W)) u_regs (
        .clk(clk), .rst_n(rst_n),
        .we(we), .waddr(addr_b), .wval(wval),
        .clr(clr), .caddr(addr_a),
        .addr_a(addr_a), .data_a(data_a), .tag_a(tag_a),
        .addr_b(addr_b), .tag_b(tag_b)
    );

    fprs_topptr #(.NREG(NREG)) u_ptr (
        .clk(clk), .rst_n(rst_n),
        .step_dn(step_dn), .step_up(step_up), .top(top)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rd_data  <= '0;
            rd_tag   <= 1'b0;
            fault    <= FLT_NONE;
            resp_vld <= 1'b0;
            last_op  <= OP_NOP;
        end else begin
            if (rd_upd) begin
                rd_data <= rd_val;
                rd_tag  <= rd_tag_val;
            end
            fault    <= fault_nxt;
            resp_vld <= (op != OP_NOP);
            last_op  <= op;
        end
    end

    assign top_ptr = top;

    AST_FAULT_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
        fault != 2'b11); // R10

    AST_NOP_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (last_op == OP_NOP) |-> (fault == FLT_NONE && !resp_vld && top_ptr == $past(top_ptr))); // R10

    AST_PUSH_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (last_op == OP_PUSH) |-> (top_ptr == $past(top_ptr) - ONE)); // R3

    AST_POP_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (last_op == OP_POP) |-> (top_ptr == $past(top_ptr) + ONE)); // R4

    AST_EXAM_NO_FAULT: assert property (@(posedge clk) disable iff (!rst_n)
        (last_op == OP_EXAM) |-> (fault == FLT_NONE)); // R8

    AST_COPY_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        (last_op == OP_COPY) |-> (fault != FLT_OVER)); // R9

    AST_UNDERFLOW_NAN: assert property (@(posedge clk) disable iff (!rst_n)
        (fault == FLT_UNDER && (last_op == OP_READ || last_op == OP_POP)) |-> (rd_data == NAN_PAT && !rd_tag)); // R5

endmodule

// File: tb/fprs_stack_test.sv
module fprs_stack_test;
    localparam logic [2:0] C_NOP = 3'd0, C_PUSH = 3'd1, C_POP = 3'd2, C_READ = 3'd3,
                           C_WRITE = 3'd4, C_COPY = 3'd5, C_MOD = 3'd6, C_EXAM = 3'd7;
    localparam logic [63:0] NAN = 64'h7FF8_0000_0000_0000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [2:0]  op_code = C_NOP;
    logic [2:0]  op_idx = '0;
    logic [63:0] op_wdata = '0;
    logic [63:0] rd_data;
    logic        rd_tag;
    logic [1:0]  fault;
    logic        resp_vld;
    logic [2:0]  top_ptr;

    int n_chk = 0;
    int n_fail = 0;

    logic [63:0] m_data [8];
    logic        m_tag  [8];
    logic [2:0]  m_top;
    logic [63:0] m_rd;
    logic        m_rtag;

    always #4 clk = ~clk;

    fprs_stack uut (
        .clk(clk), .rst_n(rst_n), .op_code(op_code), .op_idx(op_idx),
        .op_wdata(op_wdata), .rd_data(rd_data), .rd_tag(rd_tag),
        .fault(fault), .resp_vld(resp_vld), .top_ptr(top_ptr)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        op_code = C_NOP;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        for (int k = 0; k < 8; k++) begin
            m_data[k] = '0;
            m_tag[k]  = 1'b0;
        end
        m_top = '0; m_rd = '0; m_rtag = 1'b0;
        @(negedge clk);
        check(top_ptr == 3'd0, "R1", "reset top", 64'(top_ptr), 64'd0);
        check(fault == 2'b00 && !resp_vld, "R1", "reset fault/vld", 64'({fault, resp_vld}), 64'd0);
        check(rd_data == 64'd0 && !rd_tag, "R1", "reset rd_data", rd_data, 64'd0);
    endtask

    task automatic run_op(input logic [2:0] code, input logic [2:0] idx,
                          input logic [63:0] wd, input string req);
        logic [1:0] e_flt;
        logic [2:0] rel, src;
        e_flt = 2'b00;
        rel = m_top + idx;
        op_code = code; op_idx = idx; op_wdata = wd;
        case (code)
            C_PUSH: begin
                m_top = m_top - 3'd1;
                if (m_tag[m_top]) begin e_flt = 2'b10; m_data[m_top] = NAN; end
                else m_data[m_top] = wd;
                m_tag[m_top] = 1'b1;
            end
            C_POP: begin
                m_rtag = m_tag[m_top];
                m_rd = m_tag[m_top] ? m_data[m_top] : NAN;
                if (!m_tag[m_top]) e_flt = 2'b01;
                m_tag[m_top] = 1'b0;
                m_top = m_top + 3'd1;
            end
            C_READ: begin
                m_rtag = m_tag[rel];
                m_rd = m_tag[rel] ? m_data[rel] : NAN;
                if (!m_tag[rel]) e_flt = 2'b01;
            end
            C_WRITE: begin
                if (m_tag[rel]) begin e_flt = 2'b10; m_data[rel] = NAN; end
                else m_data[rel] = wd;
                m_tag[rel] = 1'b1;
            end
            C_COPY: begin
                src = m_top;
                if (!m_tag[src]) begin e_flt = 2'b01; m_data[rel] = NAN; end
                else m_data[rel] = m_data[src];
                m_tag[rel] = 1'b1;
            end
            C_MOD: begin
                m_rtag = m_tag[rel];
                m_rd = m_tag[rel] ? m_data[rel] : NAN;
                if (!m_tag[rel]) begin e_flt = 2'b01; m_data[rel] = NAN; end
                else m_data[rel] = wd;
                m_tag[rel] = 1'b1;
            end
            C_EXAM: begin
                m_rtag = m_tag[rel];
                m_rd = m_data[rel];
            end
            default: begin end
        endcase
        @(negedge clk);
        check(fault == e_flt, req, "fault code", 64'(fault), 64'(e_flt));
        check(resp_vld == (code != C_NOP), req, "resp_vld", 64'(resp_vld), 64'(code != C_NOP));
        check(top_ptr == m_top, req, "top_ptr", 64'(top_ptr), 64'(m_top));
        check(rd_data == m_rd, req, "rd_data", rd_data, m_rd);
        check(rd_tag == m_rtag, req, "rd_tag", 64'(rd_tag), 64'(m_rtag));
        op_code = C_NOP;
        @(negedge clk);
        check(fault == 2'b00 && !resp_vld, "R10", "pulse cleared", 64'({fault, resp_vld}), 64'd0);
    endtask

    task automatic exam_sweep(input string req);
        for (int i = 0; i < 8; i++) run_op(C_EXAM, 3'(i), 64'd0, req);
    endtask

    bit done = 1'b0;

    initial begin
        for (int c = 0; c < 150000 && !done; c++) @(posedge clk);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog expired: actual running expected finished");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        do_reset();
        run_op(C_NOP, 3'd0, 64'd0, "R10");
        // empty stack: checked reads underflow, examine is quiet
        for (int i = 0; i < 8; i++) run_op(C_READ, 3'(i), 64'd0, "R5");
        exam_sweep("R8");
        // modify on empty slot stores NaN
        run_op(C_MOD, 3'd2, 64'h1111, "R7");
        run_op(C_EXAM, 3'd2, 64'd0, "R7");
        // copy from empty ST(0)
        run_op(C_COPY, 3'd4, 64'd0, "R9");
        do_reset();
        // fill all eight with pushes, pointer wraps through 7
        for (int i = 0; i < 8; i++) run_op(C_PUSH, 3'd0, 64'h4000_0000_0000_0000 + 64'(i), "R3");
        run_op(C_PUSH, 3'd0, 64'hDEAD, "R6");
        for (int i = 0; i < 8; i++) run_op(C_READ, 3'(i), 64'd0, "R2");
        run_op(C_WRITE, 3'd3, 64'hBEEF, "R6");
        run_op(C_COPY, 3'd5, 64'd0, "R9");
        run_op(C_MOD, 3'd1, 64'h3FF0_0000_0000_0000, "R7");
        exam_sweep("R8");
        // pop everything, then pop past empty
        for (int i = 0; i < 8; i++) run_op(C_POP, 3'd0, 64'd0, "R4");
        run_op(C_POP, 3'd0, 64'd0, "R4");
        run_op(C_NOP, 3'd0, 64'd0, "R10");
        exam_sweep("R8");
        run_op(C_WRITE, 3'd4, 64'h1234_5678, "R6");
        // rotate through many top positions with mixed traffic
        for (int r = 0; r < 12; r++) begin
            run_op(C_PUSH, 3'd0, 64'(r * 97 + 5), "R3");
            run_op(C_READ, 3'(r % 8), 64'd0, "R2");
            run_op(C_WRITE, 3'((r * 3) % 8), 64'(r + 1000), "R6");
            if (r % 3 == 0) run_op(C_POP, 3'd0, 64'd0, "R4");
            if (r % 4 == 1) run_op(C_COPY, 3'((r + 2) % 8), 64'd0, "R9");
        end
        exam_sweep("R2");
        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule